// File: doc/BRIEF.md
# USB Start-of-Frame Timer and Trigger Pulse

This block keeps USB full-speed frame timing for either role. In host mode a down-counter on the PHY clock spaces frame starts by a programmable number of PHY clocks. At every frame start it requests a start-of-frame token, or a keep-alive token when the link runs at low speed. It also advances an 11-bit frame number and marks the event. In device mode the block follows the bus instead. Each received start-of-frame strobe loads the frame number it carries and marks the event in the same way.

Every frame start crosses into the system clock domain. There it sets a sticky interrupt flag and fires a trigger pulse exactly 20 system cycles wide, which is meant for a timer's trigger input. Software reads the frame number and the remaining clock count directly from the outputs. It clears the flag with a write-one strobe.

Top module: `usb_sof_timer`

## Requirements
- R1: In host mode, with interval value N >= 2 on `interval_i`, successive token requests are exactly N PHY clock cycles apart.
- R2: At each host frame start, exactly one of `tok_sof_o` (when `low_speed_i`=0) or `tok_keepalive_o` (when `low_speed_i`=1) is high for one PHY cycle. The two are never high together.
- R3: `frame_num_o` is 11 bits wide. It advances by one at every host frame start, in the same PHY cycle in which the token request appears, and it wraps from 2047 to 0.
- R4: In host mode, `remaining_o` equals N-1 in the cycle of a token request and falls by one on each PHY clock until it reaches 0. The next frame start follows that zero.
- R5: A new value on `interval_i` takes effect only at the next reload. The frame in progress keeps its old length.
- R6: In device mode, a one-cycle `rx_sof_i` strobe loads `rx_frame_num_i` into `frame_num_o` on the next PHY edge and counts as a frame start.
- R7: Each frame start that is not overtaken by another produces a high period on `trig_pulse_o` of exactly 20 system-clock cycles.
- R8: A frame start that arrives while the pulse is high ends that pulse. After one low cycle a fresh 20-cycle pulse follows, so pulses never merge into a longer one.
- R9: `irq_o` is set by every frame start and stays set until a `irq_clr_i` strobe. If a set and a clear fall in the same system cycle, the set wins.
- R10: In host mode, an interval value of 0 or 1 gives a frame start on every PHY cycle.
- R11: In device mode, `remaining_o` reads 0 and neither token request is ever raised.
- R12: After reset, `frame_num_o`, `remaining_o`, `irq_o`, `trig_pulse_o` and both token requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phy_clk_i | input | 1 | PHY clock; drives the frame counter |
| sys_clk_i | input | 1 | System clock; drives the interrupt flag and the trigger pulse |
| rst_ni | input | 1 | Asynchronous reset, active low, for both domains |
| host_mode_i | input | 1 | 1 selects host role, 0 selects device role (PHY domain) |
| low_speed_i | input | 1 | 1 selects keep-alive requests instead of start-of-frame requests |
| interval_i | input | 16 | PHY clocks between host frame starts |
| rx_sof_i | input | 1 | Device role: received start-of-frame strobe (PHY domain) |
| rx_frame_num_i | input | 11 | Frame number carried by the received token |
| irq_clr_i | input | 1 | Write-one-to-clear strobe for the interrupt flag (system domain) |
| tok_sof_o | output | 1 | Request to send a start-of-frame token |
| tok_keepalive_o | output | 1 | Request to send a keep-alive token |
| frame_num_o | output | 11 | Current frame number |
| remaining_o | output | 16 | PHY clocks left before the next host frame start |
| irq_o | output | 1 | Sticky start-of-frame interrupt flag |
| trig_pulse_o | output | 1 | Timer trigger pulse, 20 system cycles wide |

## Verification
A wrong count or a missed reload shows up at once on `remaining_o`, which stops stepping down by one. The same fault shows up within a frame as a token spacing that differs from the programmed interval. A broken frame-number increment or latch is visible on `frame_num_o` in the PHY cycle right after the token or strobe. Faults in the domain crossing or the pulse timer appear about three system cycles after the event: the pulse has the wrong length, the number of rising edges does not match the number of frame starts, or the interrupt flag does not rise or does not clear.

// File: rtl/sof_pkg.sv
package sof_pkg;
  localparam int unsigned FN_W    = 11;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned PULSE_W = 20;

  typedef logic [FN_W-1:0]  frame_num_t;
  typedef logic [CNT_W-1:0] frame_cnt_t;
endpackage

// File: rtl/sof_frame_ctr.sv
module sof_frame_ctr
  import sof_pkg::*;
#(
  parameter int unsigned FNW = FN_W,
  parameter int unsigned CW  = CNT_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           host_mode_i,
  input  logic           low_speed_i,
  input  logic [CW-1:0]  interval_i,
  input  logic           rx_sof_i,
  input  logic [FNW-1:0] rx_frame_num_i,
  output logic           tok_sof_o,
  output logic           tok_ka_o,
  output logic           evt_o,
  output logic [FNW-1:0] frame_num_o,
  output logic [CW-1:0]  remaining_o
);
  logic [CW-1:0] reload_val;

  // intervals of 0 and 1 both give a frame start on every cycle
  assign reload_val = (interval_i <= CW'(1)) ? '0 : interval_i - CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remaining_o <= '0;
      frame_num_o <= '0;
      tok_sof_o   <= 1'b0;
      tok_ka_o    <= 1'b0;
      evt_o       <= 1'b0;
    end else begin
      tok_sof_o <= 1'b0;
      tok_ka_o  <= 1'b0;
      evt_o     <= 1'b0;
      if (host_mode_i) begin
        if (remaining_o == '0) begin
          remaining_o <= reload_val;
          frame_num_o <= frame_num_o + FNW'(1);
          evt_o       <= 1'b1;
          tok_ka_o    <= low_speed_i;
          tok_sof_o   <= !low_speed_i;
        end else begin
          remaining_o <= remaining_o - CW'(1);
        end
      end else begin
        remaining_o <= '0;
        if (rx_sof_i) begin
          frame_num_o <= rx_frame_num_i;
          evt_o       <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sof_evt_sync.sv
module sof_evt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic src_clk_i,
  input  logic dst_clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic evt_o
);
  logic              src_tgl;
  logic [STAGES:0]   dst_q;

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni)    src_tgl <= 1'b0;
    else if (evt_i) src_tgl <= !src_tgl;
  end

  always_ff @(posedge dst_clk_i or negedge rst_ni) begin
    if (!rst_ni) dst_q <= '0;
    else         dst_q <= {dst_q[STAGES-1:0], src_tgl};
  end

  assign evt_o = dst_q[STAGES] ^ dst_q[STAGES-1];
endmodule

// File: rtl/sof_pulse_gen.sv
module sof_pulse_gen
  import sof_pkg::*;
#(
  parameter int unsigned WIDTH = PULSE_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic pulse_o
);
  localparam int unsigned CW = $clog2(WIDTH + 2);
  localparam logic [CW-1:0] START = CW'(WIDTH + 1);

  logic [CW-1:0] cnt_q;

  // START is a guard low cycle that separates back-to-back pulses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (evt_i)          cnt_q <= START;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign pulse_o = (cnt_q != '0) && (cnt_q != START);
endmodule

// File: rtl/sof_irq_flag.sv
module sof_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/usb_sof_timer.sv
module usb_sof_timer
  import sof_pkg::*;
#(
  parameter int unsigned FNW   = FN_W,
  parameter int unsigned CW    = CNT_W,
  parameter int unsigned PW    = PULSE_W,
  parameter int unsigned SYNC  = 2
) (
  input  logic           phy_clk_i,
  input  logic           sys_clk_i,
  input  logic           rst_ni,
  input  logic           host_mode_i,
  input  logic           low_speed_i,
  input  logic [CW-1:0]  interval_i,
  input  logic           rx_sof_i,
  input  logic [FNW-1:0] rx_frame_num_i,
  input  logic           irq_clr_i,
  output logic           tok_sof_o,
  output logic           tok_keepalive_o,
  output logic [FNW-1:0] frame_num_o,
  output logic [CW-1:0]  remaining_o,
  output logic           irq_o,
  output logic           trig_pulse_o
);
  logic evt_phy;
  logic evt_sys;

  sof_frame_ctr #(.FNW(FNW), .CW(CW)) ctr_i (
    .clk_i          (phy_clk_i),
    .rst_ni         (rst_ni),
    .host_mode_i    (host_mode_i),
    .low_speed_i    (low_speed_i),
    .interval_i     (interval_i),
    .rx_sof_i       (rx_sof_i),
    .rx_frame_num_i (rx_frame_num_i),
    .tok_sof_o      (tok_sof_o),
    .tok_ka_o       (tok_keepalive_o),
    .evt_o          (evt_phy),
    .frame_num_o    (frame_num_o),
    .remaining_o    (remaining_o)
  );

  sof_evt_sync #(.STAGES(SYNC)) sync_i (
    .src_clk_i (phy_clk_i),
    .dst_clk_i (sys_clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_phy),
    .evt_o     (evt_sys)
  );

  sof_irq_flag irq_i (
    .clk_i  (sys_clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_sys),
    .clr_i  (irq_clr_i),
    .flag_o (irq_o)
  );

  sof_pulse_gen #(.WIDTH(PW)) pulse_i (
    .clk_i   (sys_clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_sys),
    .pulse_o (trig_pulse_o)
  );
endmodule

module usb_sof_timer_chk #(
  parameter int unsigned FNW = 11,
  parameter int unsigned CW  = 16,
  parameter int unsigned PW  = 20
) (
  input logic           phy_clk_i,
  input logic           sys_clk_i,
  input logic           rst_ni,
  input logic           host_mode_i,
  input logic           irq_clr_i,
  input logic           tok_sof_o,
  input logic           tok_keepalive_o,
  input logic [FNW-1:0] frame_num_o,
  input logic [CW-1:0]  remaining_o,
  input logic           irq_o,
  input logic           trig_pulse_o,
  input logic           evt_sys
);
  logic [7:0] high_run;

  always_ff @(posedge sys_clk_i or negedge rst_ni) begin
    if (!rst_ni)           high_run <= '0;
    else if (trig_pulse_o) high_run <= high_run + 8'd1;
    else                   high_run <= '0;
  end

  a_r2_tok_exclusive: assert property (@(posedge phy_clk_i) disable iff (!rst_ni)
    !(tok_sof_o && tok_keepalive_o));

  a_r3_frame_advance: assert property (@(posedge phy_clk_i) disable iff (!rst_ni)
    host_mode_i && remaining_o == '0 |=> frame_num_o == $past(frame_num_o) + FNW'(1));

  a_r4_count_down: assert property (@(posedge phy_clk_i) disable iff (!rst_ni)
    host_mode_i && remaining_o != '0 |=> remaining_o == $past(remaining_o) - CW'(1));

  a_r11_no_tok_device: assert property (@(posedge phy_clk_i) disable iff (!rst_ni)
    !host_mode_i |=> !tok_sof_o && !tok_keepalive_o);

  a_r7_pulse_max: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    trig_pulse_o |-> high_run < 8'(PW));

  a_r8_guard_low: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    evt_sys |=> !trig_pulse_o ##1 trig_pulse_o);

  a_r9_irq_set: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    evt_sys |=> irq_o);

  a_r9_irq_clr: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    irq_clr_i && !evt_sys |=> !irq_o);
endmodule

bind usb_sof_timer usb_sof_timer_chk #(.FNW(FNW), .CW(CW), .PW(PW)) chk_i (
  .phy_clk_i       (phy_clk_i),
  .sys_clk_i       (sys_clk_i),
  .rst_ni          (rst_ni),
  .host_mode_i     (host_mode_i),
  .irq_clr_i       (irq_clr_i),
  .tok_sof_o       (tok_sof_o),
  .tok_keepalive_o (tok_keepalive_o),
  .frame_num_o     (frame_num_o),
  .remaining_o     (remaining_o),
  .irq_o           (irq_o),
  .trig_pulse_o    (trig_pulse_o),
  .evt_sys         (evt_sys)
);

// File: tb/usb_sof_timer_tb_top.sv
module usb_sof_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PHY_PERIOD = 2 * CLK_PERIOD;
  localparam int PW = 20;

  logic        sys_clk = 1'b0;
  logic        phy_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_mode = 1'b0;
  logic        low_speed = 1'b0;
  logic [15:0] interval = 16'd30;
  logic        rx_sof = 1'b0;
  logic [10:0] rx_fn = '0;
  logic        irq_clr = 1'b0;
  logic        tok_sof, tok_ka, irq, pulse;
  logic [10:0] frame_num;
  logic [15:0] remaining;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) sys_clk = !sys_clk;
  always #(PHY_PERIOD/2) phy_clk = !phy_clk;

  usb_sof_timer dut_i (
    .phy_clk_i(phy_clk), .sys_clk_i(sys_clk), .rst_ni(rst_n),
    .host_mode_i(host_mode), .low_speed_i(low_speed), .interval_i(interval),
    .rx_sof_i(rx_sof), .rx_frame_num_i(rx_fn), .irq_clr_i(irq_clr),
    .tok_sof_o(tok_sof), .tok_keepalive_o(tok_ka), .frame_num_o(frame_num),
    .remaining_o(remaining), .irq_o(irq), .trig_pulse_o(pulse)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [10:0] fn_next(input logic [10:0] f);
    return f + 11'd1;
  endfunction

  function automatic int exp_gap(input int n);
    return (n <= 1) ? 1 : n;
  endfunction

  // pulse monitor
  int run = 0, rises = 0, full_runs = 0, short_runs = 0, long_runs = 0;
  always @(negedge sys_clk) begin
    if (pulse) begin
      if (run == 0) rises++;
      run++;
    end else if (run != 0) begin
      if (run == PW) full_runs++;
      else if (run < PW) short_runs++;
      else long_runs++;
      run = 0;
    end
  end

  // countdown monitor and frame counter
  int frames = 0, cd_err = 0, dev_tok = 0;
  logic [15:0] prev_rem = '0;
  logic prev_host = 1'b0;
  always @(negedge phy_clk) begin
    if (rst_n) begin
      if (tok_sof || tok_ka) frames++;
      if (!host_mode && prev_host == 1'b0 && (tok_sof || tok_ka)) dev_tok++;
      if (!prev_host && !host_mode && remaining != 0) dev_tok++;
      if (host_mode && prev_host && prev_rem != 0 && remaining != prev_rem - 16'd1) cd_err++;
      prev_rem = remaining;
      prev_host = host_mode;
    end
  end

  task automatic wait_tok(output int cyc);
    cyc = 0;
    do begin
      @(negedge phy_clk);
      cyc++;
    end while (!(tok_sof || tok_ka) && cyc < 70000);
  endtask

  task automatic rx_token(input logic [10:0] f);
    @(negedge phy_clk);
    rx_sof = 1'b1; rx_fn = f;
    @(negedge phy_clk);
    rx_sof = 1'b0;
    frames++;
  endtask

  task automatic clr_irq();
    @(negedge sys_clk); irq_clr = 1'b1;
    @(negedge sys_clk); irq_clr = 1'b0;
  endtask

  task automatic drain();
    repeat (30) @(negedge sys_clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int g, n, r0, f0, sr0, fr0;
    logic [10:0] fn_exp;
    void'($urandom(32'd1234));

    // R12 reset state
    repeat (4) @(negedge sys_clk);
    check(frame_num == 0 && remaining == 0, "R12", "frame/remaining in reset", frame_num, 0);
    check(!irq && !pulse && !tok_sof && !tok_ka, "R12", "flags in reset", {irq, pulse, tok_sof, tok_ka}, 0);
    @(negedge phy_clk); rst_n = 1'b1;

    // R11 device idle: no tokens, remaining 0
    repeat (20) @(negedge phy_clk);
    check(remaining == 0 && dev_tok == 0, "R11", "device idle", remaining, 0);

    // R6 device latch, R7 full pulse, R9 irq
    rx_token(11'd1234);
    check(frame_num == 11'd1234, "R6", "latched frame number", frame_num, 1234);
    drain();
    check(irq == 1'b1, "R9", "irq set by frame start", irq, 1);
    check(full_runs == 1 && rises == 1, "R7", "single 20-cycle pulse", full_runs, 1);
    clr_irq();
    @(negedge sys_clk);
    check(irq == 1'b0, "R9", "irq cleared by strobe", irq, 0);

    // random device frame numbers
    for (int i = 0; i < 6; i++) begin
      logic [10:0] f = 11'($urandom_range(0, 2047));
      rx_token(f);
      check(frame_num == f, "R6", "random latch", frame_num, f);
      drain();
    end
    check(full_runs == 7 && short_runs == 0 && long_runs == 0, "R7", "all device pulses 20 wide", full_runs, 7);

    // R8 overlap: second strobe during pulse
    fr0 = full_runs; sr0 = short_runs; r0 = rises;
    rx_token(11'd5);
    repeat (3) @(negedge phy_clk);
    rx_token(11'd6);
    drain();
    check(short_runs == sr0 + 1 && full_runs == fr0 + 1 && long_runs == 0, "R8", "cut pulse then fresh pulse",
          short_runs - sr0, 1);
    check(rises == r0 + 2, "R8", "two distinct rising edges", rises - r0, 2);

    // R9 set wins over concurrent clear
    @(negedge sys_clk); irq_clr = 1'b1;
    repeat (2) @(negedge sys_clk);
    check(irq == 1'b0, "R9", "cleared while clear held", irq, 0);
    begin
      bit seen = 0;
      rx_token(11'd7);
      repeat (12) begin
        @(negedge sys_clk);
        if (irq) seen = 1;
      end
      check(seen, "R9", "set wins while clear held", seen, 1);
      check(irq == 1'b0, "R9", "clear resumes after set", irq, 0);
    end
    @(negedge sys_clk); irq_clr = 1'b0;

    // R3 wrap: latch 2047 then go host
    rx_token(11'd2047);
    @(negedge phy_clk);
    interval = 16'd24; host_mode = 1'b1;
    wait_tok(g);
    check(frame_num == 11'd0, "R3", "wrap 2047 to 0", frame_num, 0);
    check(tok_sof && !tok_ka, "R2", "full-speed SOF request", {tok_sof, tok_ka}, 2);
    check(remaining == 16'd23, "R4", "remaining after reload", remaining, 23);
    wait_tok(g);
    check(g == 24, "R1", "token spacing", g, 24);
    check(frame_num == 11'd1, "R3", "increment", frame_num, 1);

    // R2 low speed keep-alive
    low_speed = 1'b1;
    wait_tok(g);
    check(tok_ka && !tok_sof, "R2", "keep-alive request", {tok_sof, tok_ka}, 1);
    low_speed = 1'b0;

    // R5 change mid-frame: current frame keeps old length
    wait_tok(g);
    interval = 16'd40;
    wait_tok(g);
    check(g == 24, "R5", "old interval finishes frame", g, 24);
    wait_tok(g);
    check(g == 40, "R5", "new interval after reload", g, 40);

    // random intervals
    for (int i = 0; i < 8; i++) begin
      n = $urandom_range(12, 60);
      interval = 16'(n);
      wait_tok(g);
      fn_exp = fn_next(frame_num);
      wait_tok(g);
      check(g == exp_gap(n), "R1", "random spacing", g, exp_gap(n));
      check(frame_num == fn_exp, "R3", "random increment", frame_num, fn_exp);
      check(remaining == 16'(n - 1), "R4", "reload value", remaining, n - 1);
    end

    // R10 interval 0 and 1
    interval = 16'd1;
    wait_tok(g); wait_tok(g);
    wait_tok(g);
    check(g == 1, "R10", "interval 1 every cycle", g, 1);
    interval = 16'd0;
    wait_tok(g); wait_tok(g);
    wait_tok(g);
    check(g == 1, "R10", "interval 0 every cycle", g, 1);
    interval = 16'd30;
    wait_tok(g); wait_tok(g);

    // back to device, drain, compare counts
    @(negedge phy_clk); host_mode = 1'b0;
    drain(); drain();
    check(cd_err == 0, "R4", "countdown monitor errors", cd_err, 0);
    check(long_runs == 0, "R8", "no merged pulses", long_runs, 0);
    check(rises == frames, "R7", "one pulse per frame start", rises, frames);
    f0 = full_runs;
    rx_token(11'd9);
    drain();
    check(full_runs == f0 + 1, "R7", "final pulse width", full_runs - f0, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule